// File: doc/BRIEF.md
# Transceiver Scan and Duplex Resolver

This block finds the transceivers on a management bus and works out the duplex mode of the link. It issues register reads through a simple request/response port that a separate serial management engine carries out. It probes each transceiver address in ascending order and counts a device as present when its status register gives a believable value. It stores the addresses it finds in order, together with the advertisement word of the most recent find.

When the scan ends, the block reads the link partner ability word of the first transceiver it found. It ANDs that word with the stored advertisement and resolves full or half duplex. The result goes out as a bit in a caller-supplied configuration word. The sequence runs once by itself after reset, and again each time `start` is pulsed. A host can freeze the duplex decision with `dup_lock`.

Top module: `phy_scan_top`

## Requirements
- R1: After reset the outputs read busy=1, mdio_req=0, phy_cnt=0, phy_found=0, no_phy=0, full_dup=0. The first scan then starts with no other stimulus.
- R2: Only one read is outstanding at a time. mdio_req, mdio_phy and mdio_reg hold steady until mdio_done, and status probes (register 1) visit addresses 1 through 31 in rising order. Address 0 is never probed.
- R3: An address is counted as present only if its register 1 reads neither 16'hFFFF nor 16'h0000.
- R4: The scan stops as soon as 4 transceivers have been found, even if some addresses are still unprobed.
- R5: Each present address is followed at once by a read of its register 4. Output adv holds the value from the last transceiver found, and is 0 when none was found.
- R6: After a scan that found at least one device, exactly one read of register 5 goes to the first address found. That read is the last one of the sequence.
- R7: The negotiated word is register 5 AND adv. full_dup becomes 1 when its bit 8 is set, or when its bits 8:6 equal 3'b001. Otherwise full_dup becomes 0.
- R8: full_dup stays unchanged when register 5 reads 16'hFFFF, or when dup_lock is high as that read completes.
- R9: cfg_out equals cfg_in with bit 9 replaced by full_dup.
- R10: When no device is found, no_phy=1, phy_cnt=0 and phy_found=0. No register 5 read takes place and full_dup is unchanged.
- R11: phy_list slot k (bits 5k+4:5k) holds the address of the (k+1)-th device found, first_phy equals slot 0, and phy_cnt is the number found.
- R12: A start pulse while idle restarts the whole sequence. On the next cycle busy=1, phy_cnt=0 and no_phy=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart the scan |
| dup_lock | input | 1 | Freeze the duplex decision |
| cfg_in | input | 32 | Configuration word to merge into |
| mdio_req | output | 1 | Read request, held until done |
| mdio_phy | output | 5 | Transceiver address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_done | input | 1 | One-cycle completion of the request |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| busy | output | 1 | Sequence in progress |
| phy_cnt | output | 3 | Number of transceivers found |
| phy_found | output | 1 | At least one transceiver found |
| no_phy | output | 1 | Scan finished with nothing found |
| first_phy | output | 5 | Address of the first transceiver found |
| phy_list | output | 20 | Found addresses, 5 bits per slot |
| adv | output | 16 | Stored advertisement word |
| full_dup | output | 1 | Resolved duplex |
| cfg_out | output | 32 | cfg_in with bit 9 set to full_dup |

## Verification
A wrong scan address or a misjudged presence test first appears in the order of requests on the management port. The bench therefore records every request and compares the whole trace with the trace it expects. A corrupted found list or advertisement stays invisible until the scan ends, and then shows up in phy_list, adv and the register 5 address. A bad duplex decision shows on full_dup and cfg_out bit 9 in the cycle after the register 5 read completes, and it also carries into the later runs that are supposed to leave it unchanged.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [4:0] REG_LPA  = 5'd5;
  localparam int         FD_BIT   = 9;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_PROBE, ST_ADV, ST_PART
  } scan_state_t;

  function automatic logic phy_present(input logic [15:0] stat);
    return (stat != 16'hFFFF) && (stat != 16'h0000);
  endfunction

  function automatic logic duplex_resolve(input logic [15:0] lpa, input logic [15:0] adv_w);
    logic [15:0] neg;
    neg = lpa & adv_w;
    return neg[8] || (neg[8:6] == 3'b001);
  endfunction

  function automatic logic [31:0] merge_cfg(input logic [31:0] cfg, input logic fd);
    logic [31:0] r;
    r = cfg;
    r[FD_BIT] = fd;
    return r;
  endfunction
endpackage

// File: rtl/phy_found_list.sv
module phy_found_list #(
  parameter int MAX_PHY = 4,
  parameter int ADDR_W  = 5,
  localparam int CNT_W  = $clog2(MAX_PHY + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic                      push,
  input  logic [ADDR_W-1:0]         push_addr,
  output logic [CNT_W-1:0]          cnt,
  output logic [MAX_PHY*ADDR_W-1:0] list_flat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (push)  cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < MAX_PHY; k++) begin : g_slot
    logic [ADDR_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               slot_q <= '0;
      else if (clear)                           slot_q <= '0;
      else if (push && (cnt == CNT_W'(k)))      slot_q <= push_addr;
    end
    assign list_flat[k*ADDR_W +: ADDR_W] = slot_q;
  end

  // R4: never more than MAX_PHY entries
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CNT_W'(MAX_PHY)));
endmodule

// File: rtl/duplex_unit.sv
module duplex_unit
  import phy_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        update,
  input  logic        lock,
  input  logic [15:0] lpa,
  input  logic [15:0] adv_w,
  input  logic [31:0] cfg_in,
  output logic        full_dup,
  output logic [31:0] cfg_out
);
  logic apply;
  assign apply = update && !lock && (lpa != 16'hFFFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     full_dup <= 1'b0;
    else if (apply) full_dup <= duplex_resolve(lpa, adv_w);
  end

  assign cfg_out = merge_cfg(cfg_in, full_dup);

  // R8: a locked or all-ones partner read leaves the decision alone
  a_r8_hold_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (update && (lock || lpa == 16'hFFFF)) |=> $stable(full_dup));
  a_r8_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(full_dup));
endmodule

// File: rtl/phy_scan_top.sv
module phy_scan_top
  import phy_scan_pkg::*;
#(
  parameter int MAX_PHY    = 4,
  parameter int ADDR_W     = 5,
  parameter int FIRST_ADDR = 1,
  parameter int LAST_ADDR  = 31,
  localparam int CNT_W     = $clog2(MAX_PHY + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      dup_lock,
  input  logic [31:0]               cfg_in,
  output logic                      mdio_req,
  output logic [ADDR_W-1:0]         mdio_phy,
  output logic [4:0]                mdio_reg,
  input  logic                      mdio_done,
  input  logic [15:0]               mdio_rdata,
  output logic                      busy,
  output logic [CNT_W-1:0]          phy_cnt,
  output logic                      phy_found,
  output logic                      no_phy,
  output logic [ADDR_W-1:0]         first_phy,
  output logic [MAX_PHY*ADDR_W-1:0] phy_list,
  output logic [15:0]               adv,
  output logic                      full_dup,
  output logic [31:0]               cfg_out
);
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(FIRST_ADDR);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(LAST_ADDR);

  scan_state_t        st;
  logic [ADDR_W-1:0]  addr_q;

  logic rsp_ok, restart, probe_hit, probe_miss, adv_take, part_take;
  logic cnt_full, scan_end;

  assign restart    = start || (st == ST_BOOT);
  assign rsp_ok     = mdio_req && mdio_done;
  assign probe_hit  = (st == ST_PROBE) && rsp_ok && phy_present(mdio_rdata);
  assign probe_miss = (st == ST_PROBE) && rsp_ok && !phy_present(mdio_rdata);
  assign adv_take   = (st == ST_ADV) && rsp_ok;
  assign part_take  = (st == ST_PART) && rsp_ok;
  assign cnt_full   = (phy_cnt == CNT_W'(MAX_PHY));
  assign scan_end   = (addr_q == A_LAST) || cnt_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_BOOT;
      addr_q <= A_FIRST;
      adv    <= '0;
      no_phy <= 1'b0;
    end else if (restart) begin
      st     <= ST_PROBE;
      addr_q <= A_FIRST;
      adv    <= '0;
      no_phy <= 1'b0;
    end else begin
      if (probe_hit) st <= ST_ADV;
      if (adv_take) adv <= mdio_rdata;
      if (probe_miss || adv_take) begin
        if (scan_end) begin
          if (phy_cnt == '0) begin
            st     <= ST_IDLE;
            no_phy <= 1'b1;
          end else begin
            st <= ST_PART;
          end
        end else begin
          st     <= ST_PROBE;
          addr_q <= addr_q + 1'b1;
        end
      end
      if (part_take) st <= ST_IDLE;
    end
  end

  always_comb begin
    mdio_req = (st == ST_PROBE) || (st == ST_ADV) || (st == ST_PART);
    unique case (st)
      ST_ADV:  mdio_reg = REG_ADV;
      ST_PART: mdio_reg = REG_LPA;
      default: mdio_reg = REG_STAT;
    endcase
    mdio_phy = (st == ST_PART) ? first_phy : addr_q;
  end

  assign busy      = (st != ST_IDLE);
  assign phy_found = (phy_cnt != '0);
  assign first_phy = phy_list[ADDR_W-1:0];

  phy_found_list #(.MAX_PHY(MAX_PHY), .ADDR_W(ADDR_W)) u_list (
    .clk(clk), .rst_n(rst_n), .clear(restart), .push(probe_hit && !restart),
    .push_addr(addr_q), .cnt(phy_cnt), .list_flat(phy_list)
  );

  duplex_unit u_dup (
    .clk(clk), .rst_n(rst_n), .update(part_take && !restart), .lock(dup_lock),
    .lpa(mdio_rdata), .adv_w(adv), .cfg_in(cfg_in),
    .full_dup(full_dup), .cfg_out(cfg_out)
  );

  // R2: request and its fields hold until done
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_done && !start) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)));
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_phy >= A_FIRST && mdio_phy <= A_LAST));
  // R5: a hit is followed by an advertisement read of the same address
  a_r5_adv_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit && !start) |=> (mdio_req && mdio_reg == REG_ADV && $stable(mdio_phy)));
  // R6: the partner read targets the first device found
  a_r6_part_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_reg == REG_LPA) |-> (mdio_phy == first_phy && phy_found));
  // R10: found and not-found are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(phy_found && no_phy));
endmodule

// File: tb/phy_scan_top_bench.sv
module phy_scan_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, dup_lock = 0;
  logic [31:0] cfg_in = 32'h2002_2002;
  logic mdio_req, mdio_done = 0;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata = 0;
  logic busy, phy_found, no_phy, full_dup;
  logic [2:0] phy_cnt;
  logic [4:0] first_phy;
  logic [19:0] phy_list;
  logic [15:0] adv;
  logic [31:0] cfg_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_scan_top u_phy_scan_top (
    .clk(clk), .rst_n(rst_n), .start(start), .dup_lock(dup_lock), .cfg_in(cfg_in),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_done(mdio_done), .mdio_rdata(mdio_rdata), .busy(busy),
    .phy_cnt(phy_cnt), .phy_found(phy_found), .no_phy(no_phy),
    .first_phy(first_phy), .phy_list(phy_list), .adv(adv),
    .full_dup(full_dup), .cfg_out(cfg_out)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_stat[32], m_adv[32], m_lpa[32];
  int nreq = 0;
  logic [4:0] rq_phy[64], rq_reg[64];
  logic exp_fd = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // management responder with random latency, logs every request
  initial begin
    forever begin
      @(negedge clk);
      if (mdio_req && rst_n) begin
        automatic logic [4:0] p = mdio_phy;
        automatic logic [4:0] r = mdio_reg;
        if (nreq < 64) begin rq_phy[nreq] = p; rq_reg[nreq] = r; end
        nreq++;
        repeat ($urandom % 4) @(negedge clk);
        mdio_done = 1;
        mdio_rdata = (r == 5'd1) ? m_stat[p] : (r == 5'd4) ? m_adv[p] :
                     (r == 5'd5) ? m_lpa[p] : 16'h0;
        @(negedge clk);
        mdio_done = 0;
      end
    end
  end

  task automatic clear_model();
    for (int a = 0; a < 32; a++) begin
      m_stat[a] = (a % 2) ? 16'hFFFF : 16'h0000;
      m_adv[a] = 16'h01E1; m_lpa[a] = 16'h0000;
    end
  endtask

  function automatic logic present(input logic [15:0] v);
    return !(v == 16'hFFFF || v == 16'h0000);
  endfunction

  // checks one finished sequence against the model
  task automatic check_run(input string tag);
    int ecnt = 0, en = 0, first = 0;
    logic [4:0] ep[64], er[64];
    logic [4:0] elist[4];
    logic [15:0] eadv = 0, neg;
    logic ok;
    for (int k = 0; k < 4; k++) elist[k] = 0;
    for (int a = 1; a <= 31 && ecnt < 4; a++) begin
      ep[en] = 5'(a); er[en] = 5'd1; en++;
      if (present(m_stat[a])) begin
        ep[en] = 5'(a); er[en] = 5'd4; en++;
        elist[ecnt] = 5'(a); ecnt++; eadv = m_adv[a];
      end
    end
    if (ecnt > 0) begin
      first = elist[0];
      ep[en] = 5'(first); er[en] = 5'd5; en++;
      neg = m_lpa[first] & eadv;
      if (!(m_lpa[first] == 16'hFFFF || dup_lock))
        exp_fd = neg[8] ? 1'b1 : (neg[8:6] == 3'b001);
    end
    chk({"R2 R6 request count ", tag}, nreq, en);
    ok = (nreq == en);
    for (int i = 0; i < en && ok; i++)
      if (rq_phy[i] != ep[i] || rq_reg[i] != er[i]) ok = 0;
    chk({"R2 R3 R4 R5 R6 request trace ", tag}, ok, 1);
    chk({"R11 phy_cnt ", tag}, phy_cnt, ecnt);
    chk({"R10 no_phy ", tag}, no_phy, ecnt == 0);
    chk({"R10 phy_found ", tag}, phy_found, ecnt != 0);
    chk({"R11 phy_list ", tag}, phy_list, {elist[3], elist[2], elist[1], elist[0]});
    chk({"R11 first_phy ", tag}, first_phy, elist[0]);
    chk({"R5 adv ", tag}, adv, eadv);
    chk({"R7 R8 full_dup ", tag}, full_dup, exp_fd);
    chk({"R9 cfg_out ", tag}, cfg_out, (cfg_in & ~32'h200) | (32'(exp_fd) << 9));
  endtask

  task automatic wait_idle(input string tag);
    int w = 0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    if (w >= 3000) chk({"watchdog busy ", tag}, 1, 0);
    @(negedge clk);
  endtask

  task automatic run(input string tag, input logic lk);
    dup_lock = lk;
    cfg_in = $urandom;
    @(negedge clk);
    nreq = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk({"R12 busy after start ", tag}, busy, 1);
    chk({"R12 count cleared ", tag}, phy_cnt, 0);
    chk({"R12 no_phy cleared ", tag}, no_phy, 0);
    wait_idle(tag);
    check_run(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_model();
    m_stat[3] = 16'h7849; m_adv[3] = 16'h01E1;
    m_stat[17] = 16'h0001; m_adv[17] = 16'h0181;
    m_lpa[3] = 16'h0101; // R7: AND with last adv (0181) keeps bit 8
    m_stat[0] = 16'h7809; // R2: address 0 is never probed
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 1);
    chk("R1 req in reset", mdio_req, 0);
    chk("R1 count in reset", phy_cnt, 0);
    chk("R1 flags in reset", {phy_found, no_phy, full_dup}, 0);
    rst_n = 1;
    wait_idle("boot");
    check_run("boot");

    clear_model();
    run("none", 0);                         // R10

    clear_model();
    foreach (m_stat[a]) if (a inside {1, 2, 5, 6, 9}) m_stat[a] = 16'h7809;
    m_adv[6] = 16'h01E0; m_lpa[1] = 16'h00C0; // R4 stop at 6, R7 011 -> half
    run("five", 0);

    clear_model();
    m_stat[31] = 16'h1234; m_adv[31] = 16'h0061; m_lpa[31] = 16'h0041; // R7 001 -> full
    run("last", 0);

    m_lpa[31] = 16'hFFFF;                   // R8 all-ones partner
    run("lpa_ones", 0);

    m_lpa[31] = 16'h0080;                   // would be half, R8 locked
    run("locked", 1);

    m_lpa[31] = 16'h0000;                   // R7 nothing common -> half
    run("zero_lpa", 0);

    for (int it = 0; it < 25; it++) begin
      for (int a = 0; a < 32; a++) begin
        if ($urandom % 7 == 0) begin
          m_stat[a] = 16'($urandom);
          if (!present(m_stat[a])) m_stat[a] = 16'h7809;
        end else m_stat[a] = ($urandom % 2) ? 16'hFFFF : 16'h0000;
        m_adv[a] = 16'($urandom);
        m_lpa[a] = ($urandom % 6 == 0) ? 16'hFFFF : 16'($urandom);
      end
      run($sformatf("rand%0d", it), ($urandom % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule